// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block sits in the execute stage of a five-stage integer pipeline and decides whether control flow leaves the sequential path. The ALU subtracts the second source operand from the first and reports four status bits: zero, sign (bit 31 of the difference), carry-out of the 32-bit add of the first operand and the inverted second operand plus one, and signed overflow. The unit combines these bits with the three-bit comparison code of the branch instruction. It raises a fetch-redirect select that chooses the computed branch target over the next sequential address. It raises a squash request for the younger instructions already in flight at the same time.

All six comparisons, signed and unsigned, come from the four flags alone, so no comparator is duplicated next to the ALU. Unconditional jumps, both direct and register-indirect, arrive on a separate jump qualifier and always redirect. A parameter picks whether the two outputs leave through a register stage or straight from the decision logic.

Top module: `brdec_unit`

## Requirements
- R1: With the branch qualifier high and the jump qualifier low, code 3'b000 (equal) redirects exactly when zero is 1, and code 3'b001 (not equal) redirects exactly when zero is 0.
- R2: Code 3'b100 (signed less-than) redirects when sign differs from overflow, and code 3'b101 (signed greater-or-equal) redirects when sign equals overflow.
- R3: Code 3'b110 (unsigned less-than) redirects when carry is 0, meaning the subtraction borrowed, and code 3'b111 (unsigned greater-or-equal) redirects when carry is 1.
- R4: Codes 3'b010 and 3'b011 never redirect when only the branch qualifier is high, for any flag values.
- R5: With both qualifiers low, the redirect select is 0 whatever the code and flag inputs are.
- R6: With the jump qualifier high, the redirect select is 1 whatever the branch qualifier, code and flag values are.
- R7: The squash request always equals the redirect select.
- R8: With OUT_STAGE=1 both outputs reflect the inputs sampled at the previous rising clock edge. With OUT_STAGE=0 they follow the inputs in the same cycle.
- R9: With OUT_STAGE=1, a synchronous active-high reset drives both outputs to 0 at the next rising edge and holds them at 0 while reset stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| branch_i | input | 1 | Instruction in execute is a conditional branch |
| jump_i | input | 1 | Instruction in execute is an unconditional jump |
| funct3_i | input | 3 | Comparison code of the branch |
| zero_i | input | 1 | ALU difference is zero |
| sign_i | input | 1 | Bit 31 of the ALU difference |
| carry_i | input | 1 | Carry-out of the subtraction (1 means no borrow) |
| ovf_i | input | 1 | Signed overflow of the subtraction |
| pc_src_o | output | 1 | 1 selects the branch or jump target for fetch |
| flush_o | output | 1 | Squash request for younger pipeline stages |

## Verification
The bench builds two copies of the block: one with the default OUT_STAGE=1 and one with OUT_STAGE=0. Together they cover both the one-cycle-late registered path and the same-cycle path, including reset behaviour of the register. The flags come from real 32-bit subtractions of chosen and random operands. The expected outcome is taken from ordinary signed and unsigned comparisons of those operands, so the flag-to-condition mapping is checked against arithmetic truth. The operand pairs include the most negative value, equal operands and zero-crossing pairs. Random flag patterns drive the jump and idle cases.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RSV2 = 3'b010,
        CMP_RSV3 = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_kind_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } alu_flags_t;

    typedef struct packed {
        logic pc_src;
        logic flush;
    } steer_t;

    localparam steer_t STEER_IDLE = '{pc_src: 1'b0, flush: 1'b0};

    // Signed "less than" from a subtraction: result sign corrected by overflow.
    function automatic logic signed_lt(alu_flags_t f);
        return f.sign ^ f.ovf;
    endfunction

    // Unsigned "less than": the subtraction borrowed, so no carry out.
    function automatic logic unsigned_lt(alu_flags_t f);
        return ~f.carry;
    endfunction

endpackage

// File: rtl/brdec_cond.sv
module brdec_cond
    import brdec_pkg::*;
(
    input  cmp_kind_e  kind_i,
    input  alu_flags_t flags_i,
    output logic       hit_o
);
    always_comb begin
        unique case (kind_i)
            CMP_EQ:   hit_o = flags_i.zero;
            CMP_NE:   hit_o = ~flags_i.zero;
            CMP_LT:   hit_o = signed_lt(flags_i);
            CMP_GE:   hit_o = ~signed_lt(flags_i);
            CMP_LTU:  hit_o = unsigned_lt(flags_i);
            CMP_GEU:  hit_o = ~unsigned_lt(flags_i);
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brdec_steer.sv
module brdec_steer
    import brdec_pkg::*;
(
    input  logic   branch_i,
    input  logic   jump_i,
    input  logic   hit_i,
    output steer_t steer_o
);
    logic take;

    always_comb begin
        take           = jump_i | (branch_i & hit_i);
        steer_o.pc_src = take;
        steer_o.flush  = take;
    end
endmodule

// File: rtl/brdec_outstage.sv
module brdec_outstage
    import brdec_pkg::*;
#(
    parameter int OUT_STAGE = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  steer_t d_i,
    output steer_t q_o
);
    generate
        if (OUT_STAGE != 0) begin : g_reg
            steer_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= STEER_IDLE;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_pass
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/brdec_unit.sv
module brdec_unit
    import brdec_pkg::*;
#(
    parameter int OUT_STAGE = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                branch_i,
    input  logic                jump_i,
    input  logic [CODE_W-1:0]   funct3_i,
    input  logic                zero_i,
    input  logic                sign_i,
    input  logic                carry_i,
    input  logic                ovf_i,
    output logic                pc_src_o,
    output logic                flush_o
);
    alu_flags_t flags;
    cmp_kind_e  kind;
    logic       cond_hit;
    steer_t     steer_now;
    steer_t     steer_out;

    assign flags = '{zero: zero_i, sign: sign_i, carry: carry_i, ovf: ovf_i};
    assign kind  = cmp_kind_e'(funct3_i);

    brdec_cond u_cond (
        .kind_i  (kind),
        .flags_i (flags),
        .hit_o   (cond_hit)
    );

    brdec_steer u_steer (
        .branch_i (branch_i),
        .jump_i   (jump_i),
        .hit_i    (cond_hit),
        .steer_o  (steer_now)
    );

    brdec_outstage #(.OUT_STAGE(OUT_STAGE)) u_out (
        .clk (clk),
        .rst (rst),
        .d_i (steer_now),
        .q_o (steer_out)
    );

    assign pc_src_o = steer_out.pc_src;
    assign flush_o  = steer_out.flush;

    // ---------------- assertions ----------------
    assert_jump_redirects_R6: assert property (@(posedge clk) disable iff (rst)
        jump_i |-> steer_now.pc_src);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!branch_i && !jump_i) |-> !steer_now.pc_src);

    assert_reserved_codes_R4: assert property (@(posedge clk) disable iff (rst)
        (branch_i && !jump_i && funct3_i[2:1] == 2'b01) |-> !steer_now.pc_src);

    assert_eq_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (branch_i && funct3_i == 3'b000 && zero_i) |-> steer_now.pc_src);

    assert_flush_match_R7: assert property (@(posedge clk) disable iff (rst)
        pc_src_o == flush_o);

    generate
        if (OUT_STAGE != 0) begin : g_chk_reg
            logic seen_q;
            always_ff @(posedge clk) begin
                if (rst) seen_q <= 1'b0;
                else     seen_q <= 1'b1;
            end

            assert_one_cycle_late_R8: assert property (@(posedge clk) disable iff (rst)
                seen_q |-> (pc_src_o == $past(steer_now.pc_src)));

            assert_reset_clears_R9: assert property (@(posedge clk)
                $past(rst) |-> (!pc_src_o && !flush_o));
        end else begin : g_chk_comb
            assert_same_cycle_R8: assert property (@(posedge clk) disable iff (rst)
                pc_src_o == steer_now.pc_src);
        end
    endgenerate

endmodule

// File: tb/brdec_unit_tb_top.sv
module brdec_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic       branch, jump, zero, sign, carry, ovf;
    logic [2:0] f3;
    logic       pc_r, fl_r, pc_c, fl_c;

    int checks   = 0;
    int failures = 0;

    brdec_unit #(.OUT_STAGE(1)) dut_i (
        .clk(clk), .rst(rst), .branch_i(branch), .jump_i(jump), .funct3_i(f3),
        .zero_i(zero), .sign_i(sign), .carry_i(carry), .ovf_i(ovf),
        .pc_src_o(pc_r), .flush_o(fl_r));

    brdec_unit #(.OUT_STAGE(0)) dut_comb (
        .clk(clk), .rst(rst), .branch_i(branch), .jump_i(jump), .funct3_i(f3),
        .zero_i(zero), .sign_i(sign), .carry_i(carry), .ovf_i(ovf),
        .pc_src_o(pc_c), .flush_o(fl_c));

    // expected outcomes of the registered copy, one per driven cycle
    bit    exp_q[$];
    string tag_q[$];

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // check registered outputs against the previous cycle's expectation, then drive
    task automatic apply(string tag, logic b, logic j, logic [2:0] c,
                         logic z, logic s, logic cy, logic o, bit exp);
        string ptag;
        bit    pexp;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            pexp = exp_q.pop_front();
            ptag = tag_q.pop_front();
            check({ptag, "/R8"}, "registered pc_src", pc_r, pexp);
            check("R7", "registered flush", fl_r, pexp);
        end
        branch = b; jump = j; f3 = c; zero = z; sign = s; carry = cy; ovf = o;
        #2;
        check(tag, "comb pc_src", pc_c, exp);
        check("R7", "comb flush", fl_c, exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // branch built from a real subtraction; expectation from plain comparisons
    task automatic br_ops(logic [2:0] c, logic [31:0] a, logic [31:0] b);
        logic [32:0] sum;
        logic [31:0] d;
        logic        z, s, cy, o;
        bit          e;
        string       t;
        sum = {1'b0, a} + {1'b0, ~b} + 33'd1;
        d   = sum[31:0];
        cy  = sum[32];
        z   = (d == 32'd0);
        s   = d[31];
        o   = (a[31] != b[31]) && (d[31] != a[31]);
        case (c)
            3'b000: begin e = (a == b);                   t = "R1"; end
            3'b001: begin e = (a != b);                   t = "R1"; end
            3'b100: begin e = ($signed(a) <  $signed(b)); t = "R2"; end
            3'b101: begin e = ($signed(a) >= $signed(b)); t = "R2"; end
            3'b110: begin e = (a <  b);                   t = "R3"; end
            3'b111: begin e = (a >= b);                   t = "R3"; end
            default: begin e = 1'b0;                      t = "R4"; end
        endcase
        apply(t, 1'b1, 1'b0, c, z, s, cy, o, e);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [31:0] corner [0:6];
        branch = 0; jump = 1; f3 = 3'b000; zero = 1; sign = 1; carry = 1; ovf = 1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "reset pc_src", pc_r, 1'b0);
        check("R9", "reset flush", fl_r, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        jump = 0;

        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h0000_0005;
        corner[6] = 32'h8000_0001;

        // corner operand pairs for every code (R1..R4)
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 7; i++)
                for (int k = 0; k < 7; k++)
                    br_ops(3'(c), corner[i], corner[k]);

        // random operands
        for (int n = 0; n < 600; n++)
            br_ops(3'($urandom_range(0, 7)), $urandom(), ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom());

        // R4: reserved codes under every flag pattern
        for (int p = 0; p < 32; p++)
            apply("R4", 1'b1, 1'b0, {2'b01, p[4]}, p[0], p[1], p[2], p[3], 1'b0);

        // R5: no qualifier, all codes and flag patterns
        for (int p = 0; p < 128; p++)
            apply("R5", 1'b0, 1'b0, p[6:4], p[0], p[1], p[2], p[3], 1'b0);

        // R6: jump with and without branch, all codes and flag patterns
        for (int p = 0; p < 256; p++)
            apply("R6", p[7], 1'b1, p[6:4], p[0], p[1], p[2], p[3], 1'b1);

        // R9: reset in the middle of a run while the inputs demand a redirect
        @(negedge clk);
        check("R8", "registered pc_src before reset", pc_r, exp_q.pop_front());
        void'(tag_q.pop_front());
        branch = 1'b0; jump = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R9", "mid-run reset pc_src", pc_r, 1'b0);
        check("R9", "mid-run reset flush", fl_r, 1'b0);
        @(negedge clk);
        check("R9", "held reset pc_src", pc_r, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "after reset jump", pc_r, 1'b1);
        check("R7", "after reset flush", fl_r, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule